// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM command bus. It runs once after every reset. It holds clock-enable low for a stable-clock interval and then raises it. It then steps the memory through the fixed start-up order, one command at a time. Every other cycle it drives a no-operation command. The order is: precharge all banks, enable the DLL through the extended mode register, write the mode register with DLL reset set, precharge all banks again, issue a parameterised number of auto-refresh commands, and write the mode register a final time with DLL reset cleared.

The fields of both register writes come from input pins: burst length, burst type, read latency and output drive strength. The gaps between commands are parameters counted in clocks. The power-on wait equals the clock frequency in MHz times the wait in microseconds. When both the last mode-register recovery time and the DLL lock interval have elapsed, a done flag rises. From then on the sequencer holds clock-enable high and drives only no-operation commands, so a normal scheduler can take over the bus. All outputs are registered.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: While reset is high, the outputs are CKE low, init_done low, the NOP code, address 0 and bank 0. The command code {cs_n,ras_n,cas_n,we_n} for NOP is 0111.
- R2: After reset is released, CKE stays low for exactly CLK_MHZ*PWR_US cycles and only NOP is driven during that time. CKE then rises and never falls again before the next reset.
- R3: CKE is high with NOP for exactly one cycle. Then exactly 5+N_REF non-NOP commands follow, in this order: precharge-all, extended register write, DLL-reset register write, precharge-all, N_REF auto-refreshes, final register write.
- R4: A precharge-all uses code 0010 with address bit AP_BIT (8 by default) high, all other address bits low, and bank 0.
- R5: The extended register write uses code 0000 with bank 01. Its address has bit 0 low (DLL on), bit 1 equal to drive_sel[0], bit 6 equal to drive_sel[1], and all other bits low.
- R6: Each mode register write uses code 0000 with bank 00. Its address carries burst_len on bits 2:0, burst_interleave on bit 3, cas_lat on bits 6:4, 0 on bit 7 and the DLL-reset flag on bit 8 (1 for the first write, 0 for the final one). Bits above 8 are 0.
- R7: The next command comes exactly T_RP cycles after a precharge-all, exactly T_MRD cycles (T_MRD at least 2) after a register write, and exactly T_RFC cycles after an auto-refresh.
- R8: init_done rises at max(final write + T_MRD, DLL-reset write + DLL_LOCK) cycles and then stays high. No non-NOP command follows it.
- R9: An auto-refresh uses code 0001 with address 0 and bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| burst_len | input | 3 | Burst-length code for mode register bits 2:0 |
| burst_interleave | input | 1 | Burst type for mode register bit 3 |
| cas_lat | input | 3 | Read-latency code for mode register bits 6:4 |
| drive_sel | input | 2 | Drive-strength bits for extended register bits 1 and 6 |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | AW | Address pins |
| ba | output | BW | Bank address pins |
| init_done | output | 1 | High once the sequence is complete |

## Verification
A wrong step or a skipped step shows up on the command pins at the next issue slot. It appears as a missing command, an extra command or a misplaced one, and the first cycle after the correct issue time already differs. A gap counter that is off by one moves every later command and the done flag by the same amount. The bench compares exact cycle indices, so such an error is caught within one gap. A lock counter that is not started, or is started at the wrong time, only shows when init_done rises. The bench chooses a lock interval longer than the trailing commands so that this instant depends on the lock counter alone.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    ST_RST, ST_PWR, ST_PRE1, ST_EMRS, ST_MRSDLL,
    ST_PRE2, ST_REF, ST_MRSFIN, ST_FIN, ST_DONE
  } seq_st_t;

  typedef enum logic [1:0] {OP_NOP, OP_PREA, OP_REF, OP_LMR} op_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  function automatic pins_t op_pins(op_t op);
    pins_t p;
    case (op)
      OP_PREA: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      OP_REF:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      OP_LMR:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/init_timer.sv
module init_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/init_cmd_reg.sv
module init_cmd_reg
  import ddr_init_pkg::*;
#(
  parameter int AW = 12,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  op_t           op,
  input  logic [AW-1:0] addr_d,
  input  logic [BW-1:0] ba_d,
  input  logic          cke_d,
  input  logic          done_d,
  output logic          cke,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic [AW-1:0] addr,
  output logic [BW-1:0] ba,
  output logic          init_done
);
  pins_t p;
  assign p = op_pins(op);

  always_ff @(posedge clk) begin
    if (rst) begin
      cke       <= 1'b0;
      cs_n      <= 1'b0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      addr      <= '0;
      ba        <= '0;
      init_done <= 1'b0;
    end else begin
      cke       <= cke_d;
      cs_n      <= p.cs_n;
      ras_n     <= p.ras_n;
      cas_n     <= p.cas_n;
      we_n      <= p.we_n;
      addr      <= addr_d;
      ba        <= ba_d;
      init_done <= done_d;
    end
  end
endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
  import ddr_init_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int PWR_US   = 200,
  parameter int T_RP     = 4,
  parameter int T_MRD    = 2,
  parameter int T_RFC    = 14,
  parameter int DLL_LOCK = 200,
  parameter int N_REF    = 2,
  parameter int AW       = 12,
  parameter int BW       = 2,
  parameter int AP_BIT   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    burst_len,
  input  logic          burst_interleave,
  input  logic [2:0]    cas_lat,
  input  logic [1:0]    drive_sel,
  output logic          cke,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic [AW-1:0] addr,
  output logic [BW-1:0] ba,
  output logic          init_done
);
  localparam int PWR_CYC = CLK_MHZ * PWR_US;
  localparam int TW      = $clog2(PWR_CYC + T_RP + T_MRD + T_RFC + 1);
  localparam int LW      = $clog2(DLL_LOCK + 1);
  localparam int REFW    = $clog2(N_REF + 1);
  localparam int DLL_BIT = 8;

  seq_st_t         state, st_nx;
  logic [REFW-1:0] ref_cnt, ref_nx;
  op_t             op;
  logic [AW-1:0]   a_d;
  logic [BW-1:0]   b_d;
  logic            cke_d, done_d;
  logic            ld, lk_ld, gap_ok, lock_ok;
  logic [TW-1:0]   ldv;

  function automatic logic [AW-1:0] mode_word(logic dll_rst);
    logic [AW-1:0] w;
    w          = '0;
    w[2:0]     = burst_len;
    w[3]       = burst_interleave;
    w[6:4]     = cas_lat;
    w[DLL_BIT] = dll_rst;
    return w;
  endfunction

  init_timer #(.W(TW)) u_gap (
    .clk(clk), .rst(rst), .load(ld), .load_val(ldv), .expired(gap_ok)
  );

  init_timer #(.W(LW)) u_lock (
    .clk(clk), .rst(rst), .load(lk_ld), .load_val(LW'(DLL_LOCK - 1)),
    .expired(lock_ok)
  );

  always_comb begin
    st_nx  = state;
    ref_nx = ref_cnt;
    op     = OP_NOP;
    a_d    = '0;
    b_d    = '0;
    cke_d  = 1'b1;
    done_d = 1'b0;
    ld     = 1'b0;
    ldv    = '0;
    lk_ld  = 1'b0;
    case (state)
      ST_RST: begin
        cke_d = 1'b0;
        ld    = 1'b1;
        ldv   = TW'(PWR_CYC - 1);
        st_nx = ST_PWR;
      end
      ST_PWR: begin
        cke_d = gap_ok;
        if (gap_ok) begin
          ld    = 1'b1;
          st_nx = ST_PRE1;
        end
      end
      ST_PRE1, ST_PRE2: begin
        if (gap_ok) begin
          op          = OP_PREA;
          a_d[AP_BIT] = 1'b1;
          ld          = 1'b1;
          ldv         = TW'(T_RP - 1);
          ref_nx      = '0;
          st_nx       = (state == ST_PRE1) ? ST_EMRS : ST_REF;
        end
      end
      ST_EMRS: begin
        if (gap_ok) begin
          op     = OP_LMR;
          b_d    = BW'(1);
          a_d[1] = drive_sel[0];
          a_d[6] = drive_sel[1];
          ld     = 1'b1;
          ldv    = TW'(T_MRD - 1);
          st_nx  = ST_MRSDLL;
        end
      end
      ST_MRSDLL: begin
        if (gap_ok) begin
          op    = OP_LMR;
          a_d   = mode_word(1'b1);
          ld    = 1'b1;
          ldv   = TW'(T_MRD - 1);
          lk_ld = 1'b1;
          st_nx = ST_PRE2;
        end
      end
      ST_REF: begin
        if (gap_ok) begin
          op     = OP_REF;
          ld     = 1'b1;
          ldv    = TW'(T_RFC - 1);
          ref_nx = ref_cnt + 1'b1;
          if (ref_cnt == REFW'(N_REF - 1)) st_nx = ST_MRSFIN;
        end
      end
      ST_MRSFIN: begin
        if (gap_ok) begin
          op    = OP_LMR;
          a_d   = mode_word(1'b0);
          ld    = 1'b1;
          ldv   = TW'(T_MRD - 1);
          st_nx = ST_FIN;
        end
      end
      ST_FIN: begin
        if (gap_ok && lock_ok) begin
          done_d = 1'b1;
          st_nx  = ST_DONE;
        end
      end
      ST_DONE: done_d = 1'b1;
      default: st_nx = ST_RST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RST;
      ref_cnt <= '0;
    end else begin
      state   <= st_nx;
      ref_cnt <= ref_nx;
    end
  end

  init_cmd_reg #(.AW(AW), .BW(BW)) u_out (
    .clk(clk), .rst(rst), .op(op), .addr_d(a_d), .ba_d(b_d),
    .cke_d(cke_d), .done_d(done_d),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .init_done(init_done)
  );
endmodule

// File: rtl/ddr_pwrup_chk.sv
module ddr_pwrup_chk #(
  parameter int AW     = 12,
  parameter int BW     = 2,
  parameter int AP_BIT = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cke,
  input logic          cs_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic [AW-1:0] addr,
  input logic [BW-1:0] ba,
  input logic          init_done
);
  logic [3:0] cmd;
  assign cmd = {cs_n, ras_n, cas_n, we_n};

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!cke && !init_done && cmd == 4'b0111 && addr == '0 && ba == '0));

  // R2
  cke_low_nop_chk: assert property (@(posedge clk) disable iff (rst)
    !cke |-> cmd == 4'b0111);

  // R2
  cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  // R4
  prea_ap_chk: assert property (@(posedge clk) disable iff (rst)
    cmd == 4'b0010 |-> addr[AP_BIT]);

  // R6
  mrs_tm_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000 && ba == '0) |-> !addr[7]);

  // R7
  mrd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    cmd == 4'b0000 |=> cmd == 4'b0111);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cke && cmd == 4'b0111));
endmodule

bind ddr_pwrup_seq ddr_pwrup_chk #(.AW(AW), .BW(BW), .AP_BIT(AP_BIT)) u_chk (.*);

// File: tb/sim_ddr_pwrup_seq.sv
module sim_ddr_pwrup_seq;
  localparam int P_MHZ = 1, P_US = 10, P_RP = 3, P_MRD = 2, P_RFC = 5;
  localparam int P_LOCK = 24, P_NREF = 2;
  localparam int PCYC = P_MHZ * P_US;
  localparam int NCMD = 5 + P_NREF;
  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001, C_LMR = 4'b0000;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] burst_len = '0, cas_lat = '0;
  logic burst_interleave = 1'b0;
  logic [1:0] drive_sel = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [11:0] addr;
  logic [1:0] ba;

  always #5 clk = ~clk;

  ddr_pwrup_seq #(.CLK_MHZ(P_MHZ), .PWR_US(P_US), .T_RP(P_RP), .T_MRD(P_MRD),
    .T_RFC(P_RFC), .DLL_LOCK(P_LOCK), .N_REF(P_NREF)) u0 (
    .clk(clk), .rst(rst), .burst_len(burst_len),
    .burst_interleave(burst_interleave), .cas_lat(cas_lat),
    .drive_sel(drive_sel), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .init_done(init_done));

  int checks = 0, errors = 0;
  int idx, cke_at, done_at, n_cmd, low_bad, post_done;
  logic [3:0] lc [0:15];
  int lt [0:15];
  logic [11:0] la [0:15];
  logic [1:0] lb [0:15];

  always @(posedge clk) begin
    #2;
    if (rst) begin
      idx = 0; cke_at = -1; done_at = -1; n_cmd = 0; low_bad = 0; post_done = 0;
    end else begin
      if (cke && cke_at < 0) cke_at = idx;
      if (!cke && {cs_n, ras_n, cas_n, we_n} != C_NOP) low_bad++;
      if (cke_at >= 0 && !cke) low_bad++;
      if (done_at >= 0 && !init_done) post_done++;
      if (init_done && done_at < 0) done_at = idx;
      if ({cs_n, ras_n, cas_n, we_n} != C_NOP) begin
        if (done_at >= 0) post_done++;
        if (n_cmd < 16) begin
          lc[n_cmd] = {cs_n, ras_n, cas_n, we_n};
          lt[n_cmd] = idx; la[n_cmd] = addr; lb[n_cmd] = ba;
        end
        n_cmd++;
      end
      idx++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [2:0] bl, input logic bt,
                         input logic [2:0] cl, input logic [1:0] drv, input bit first);
    logic [3:0]  eo [0:NCMD-1];
    int          et [0:NCMD-1];
    logic [11:0] ea [0:NCMD-1];
    logic [1:0]  eb [0:NCMD-1];
    int exp_done, lim;
    @(negedge clk);
    rst = 1'b1;
    burst_len = bl; burst_interleave = bt; cas_lat = cl; drive_sel = drv;
    repeat (3) @(negedge clk);
    if (first) begin
      // R1 reset state
      chk(!cke && !init_done && {cs_n, ras_n, cas_n, we_n} == C_NOP
          && addr == 12'd0 && ba == 2'd0, "R1 reset outputs",
          {cke, init_done, cs_n, ras_n, cas_n, we_n}, 6'b000111);
    end
    rst = 1'b0;
    lim = 0;
    while (done_at < 0 && lim < 400) begin @(negedge clk); lim++; end
    repeat (6) @(negedge clk);

    eo[0] = C_PRE; et[0] = PCYC + 1;             ea[0] = 12'h100; eb[0] = 2'd0;
    eo[1] = C_LMR; et[1] = et[0] + P_RP;
    ea[1] = (12'(drv[0]) << 1) | (12'(drv[1]) << 6); eb[1] = 2'd1;
    eo[2] = C_LMR; et[2] = et[1] + P_MRD;
    ea[2] = {3'b000, 1'b1, 1'b0, cl, bt, bl};   eb[2] = 2'd0;
    eo[3] = C_PRE; et[3] = et[2] + P_MRD;       ea[3] = 12'h100; eb[3] = 2'd0;
    for (int k = 0; k < P_NREF; k++) begin
      eo[4+k] = C_REF; ea[4+k] = 12'd0; eb[4+k] = 2'd0;
      et[4+k] = (k == 0) ? et[3] + P_RP : et[3+k] + P_RFC;
    end
    eo[NCMD-1] = C_LMR; et[NCMD-1] = et[NCMD-2] + P_RFC;
    ea[NCMD-1] = {3'b000, 1'b0, 1'b0, cl, bt, bl}; eb[NCMD-1] = 2'd0;
    exp_done = et[NCMD-1] + P_MRD;
    if (et[2] + P_LOCK > exp_done) exp_done = et[2] + P_LOCK;

    chk(cke_at == PCYC, "R2 cke rise cycle", cke_at, PCYC);
    chk(low_bad == 0, "R2 nop while cke low / cke stays high", low_bad, 0);
    chk(n_cmd == NCMD, "R3 command count", n_cmd, NCMD);
    for (int k = 0; k < NCMD && k < n_cmd; k++) begin
      chk(lc[k] == eo[k], "R3 command order", int'(lc[k]), int'(eo[k]));
      if (k == 0) chk(lt[k] == cke_at + 1, "R3 one nop after cke", lt[k], cke_at + 1);
      else chk(lt[k] == et[k], "R7 command spacing", lt[k], et[k]);
      if (eo[k] == C_PRE)
        chk(la[k] == ea[k] && lb[k] == eb[k], "R4 precharge address", int'(la[k]), int'(ea[k]));
      else if (eo[k] == C_REF)
        chk(la[k] == ea[k] && lb[k] == eb[k], "R9 refresh address", int'(la[k]), int'(ea[k]));
      else if (k == 1)
        chk(la[k] == ea[k] && lb[k] == eb[k], "R5 extended register word",
            int'({lb[k], la[k]}), int'({eb[k], ea[k]}));
      else
        chk(la[k] == ea[k] && lb[k] == eb[k], "R6 mode register word",
            int'({lb[k], la[k]}), int'({eb[k], ea[k]}));
    end
    chk(done_at == exp_done, "R8 init_done cycle", done_at, exp_done);
    chk(post_done == 0, "R8 quiet and held after done", post_done, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++)
      run_one(3'(i), i[3], 3'(i >> 4), 2'(i), i == 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule